// File: doc/BRIEF.md
# Host I/O Write Target for a Four-Bit Multiplexed Bus

This block is a bus target on a 4-bit multiplexed host bus. It is clocked by the bus clock. It watches an active-low frame strobe and the 4-bit nibble bus, decodes host I/O write cycles, and passes the address and data byte to a back-end port. The back-end port uses a valid/acknowledge handshake. I/O read cycles and memory read cycles can also be decoded, each under its own enable input.

Once the host has turned the bus around, the target holds the cycle open with a long-wait sync nibble on every clock until the back end acknowledges. It then returns a ready sync, any read data, and a final turnaround nibble, and releases the bus. The nibble bus is split into an input, an output and an output enable, so that the pad ring can build the tri-state driver.

Top module: `lpcw_target`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `bus_nib_oe`, `be_valid` and `be_write` are low.
- R2: A cycle begins on a clock where `bus_frame_n` is low and `bus_nib_i` is 0000. On the next clock `bus_frame_n` is high, and the nibble sampled then is the cycle type; 0010 selects an I/O write. Four address nibbles follow, most significant first. They appear zero-extended on `be_addr`.
- R3: An I/O write then carries two data nibbles, low nibble first: A then 5 gives `be_wdata` = 0x5A. The cycle raises `be_write` = 1.
- R4: `be_valid` rises one clock after the clock that samples the last address nibble (reads) or the last data nibble (writes). It then holds, with `be_addr`, `be_wdata` and `be_write` stable, up to and including the clock where `be_ack` is sampled high. It is low on the clock after that.
- R5: `bus_nib_oe` stays low during the two turnaround clocks that follow the host's last nibble.
- R6: After turnaround, the target drives 0110 with `bus_nib_oe` high on every clock until the acknowledge has been seen. The number of these clocks equals the number of clocks the back end delayed its acknowledge. The target then drives 0000 for one clock, then 1111 for one clock, then lowers `bus_nib_oe`.
- R7: With `rd_en` high, cycle type 0000 is an I/O read: four address nibbles, `be_write` = 0, then the long-wait and ready syncs, then `be_rdata` (sampled at the acknowledge), low nibble first, then 1111, then release.
- R8: With `rd_en` and `memrd_en` both high, cycle type 0100 is a memory read. It carries eight address nibbles, of which the low 24 bits reach `be_addr`. Its data phase is the same as an I/O read.
- R9: Any other cycle type is ignored: `bus_nib_oe` and `be_valid` stay low. This includes type 0000 with `rd_en` low and type 0100 with `memrd_en` low.
- R10: `bus_frame_n` low in the middle of a cycle aborts it: `bus_nib_oe` is low on the next clock. If the nibble was 0000, a new cycle starts at once.
- R11: A `be_valid` already raised when a cycle is aborted stays high until `be_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Accept read cycles |
| memrd_en | input | 1 | Also accept memory read cycles (needs rd_en) |
| bus_frame_n | input | 1 | Active-low frame strobe from the host |
| bus_nib_i | input | 4 | Nibble bus as seen by the target |
| bus_nib_o | output | 4 | Nibble driven by the target |
| bus_nib_oe | output | 1 | Output enable for `bus_nib_o` |
| be_addr | output | ADDR_W | Back-end address |
| be_wdata | output | 8 | Back-end write byte |
| be_rdata | input | 8 | Back-end read byte, sampled at the acknowledge |
| be_write | output | 1 | High for a write request |
| be_valid | output | 1 | Request outstanding |
| be_ack | input | 1 | Back-end acknowledge |

## Verification
The hardest state to reach is an abort that lands while the target is already stretching the cycle with long-wait syncs. In that state the bus has been released but the back-end request is still open. The bench holds back its acknowledge responder, walks a write into the long-wait phase, and then pulls the frame strobe low. It checks that the bus is released at once, that the request persists until the responder is re-enabled, and that the next full cycle runs normally. The acknowledge delay is swept so that the count of long-wait nibbles can be compared with it, and this includes the zero-delay case where the ready sync follows the turnaround directly.

// File: rtl/lpcw_pkg.sv
package lpcw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_DATA, ST_TAR,
    ST_WAIT, ST_SYNC, ST_RDLO, ST_RDHI, ST_TEND
  } lpcw_state_e;

  typedef enum logic [1:0] {
    K_NONE, K_IOWR, K_IORD, K_MEMRD
  } lpcw_kind_e;

  localparam logic [3:0] CODE_START = 4'h0;
  localparam logic [3:0] TYPE_IOWR  = 4'h2;
  localparam logic [3:0] TYPE_IORD  = 4'h0;
  localparam logic [3:0] TYPE_MEMRD = 4'h4;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_LWAIT = 4'h6;
  localparam logic [3:0] NIB_TAR    = 4'hF;

endpackage

// File: rtl/lpcw_seq.sv
module lpcw_seq
  import lpcw_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int IO_NIBS  = 4,
  parameter int MEM_NIBS = 8,
  localparam int CNT_W   = $clog2(MEM_NIBS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        nib_i,
  input  logic              rd_en,
  input  logic              memrd_en,
  input  logic              done_now,
  output lpcw_state_e       state_q,
  output lpcw_state_e       state_nx,
  output lpcw_kind_e        kind_q,
  output logic [ADDR_W-1:0] addr_sh,
  output logic [7:0]        wbyte
);

  logic [CNT_W-1:0] cnt;
  lpcw_kind_e       kind_dec;
  logic             addr_last;
  logic             mid_cycle;
  logic             counted;

  always_comb begin
    kind_dec = K_NONE;
    if (nib_i == TYPE_IOWR)                              kind_dec = K_IOWR;
    else if (nib_i == TYPE_IORD && rd_en)                kind_dec = K_IORD;
    else if (nib_i == TYPE_MEMRD && rd_en && memrd_en)   kind_dec = K_MEMRD;
  end

  assign addr_last = (kind_q == K_MEMRD) ? (cnt == CNT_W'(MEM_NIBS - 1))
                                         : (cnt == CNT_W'(IO_NIBS - 1));
  assign mid_cycle = (state_q != ST_IDLE) && (state_q != ST_TYPE);
  assign counted   = (state_q == ST_ADDR) || (state_q == ST_DATA) || (state_q == ST_TAR);

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE: if (!frame_n && nib_i == CODE_START) state_nx = ST_TYPE;
      ST_TYPE: begin
        if (!frame_n)                state_nx = (nib_i == CODE_START) ? ST_TYPE : ST_IDLE;
        else if (kind_dec != K_NONE) state_nx = ST_ADDR;
        else                         state_nx = ST_IDLE;
      end
      ST_ADDR: if (addr_last) state_nx = (kind_q == K_IOWR) ? ST_DATA : ST_TAR;
      ST_DATA: if (cnt == CNT_W'(1)) state_nx = ST_TAR;
      ST_TAR:  if (cnt == CNT_W'(1)) state_nx = done_now ? ST_SYNC : ST_WAIT;
      ST_WAIT: if (done_now) state_nx = ST_SYNC;
      ST_SYNC: state_nx = (kind_q == K_IOWR) ? ST_TEND : ST_RDLO;
      ST_RDLO: state_nx = ST_RDHI;
      ST_RDHI: state_nx = ST_TEND;
      ST_TEND: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
    if (mid_cycle && !frame_n)
      state_nx = (nib_i == CODE_START) ? ST_TYPE : ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= K_NONE;
      cnt     <= '0;
      addr_sh <= '0;
      wbyte   <= '0;
    end else begin
      state_q <= state_nx;
      if (state_nx != state_q) cnt <= '0;
      else if (counted)        cnt <= cnt + CNT_W'(1);
      if (state_q == ST_TYPE && frame_n) kind_q <= kind_dec;
      if (state_q == ST_TYPE)      addr_sh <= '0;
      else if (state_q == ST_ADDR) addr_sh <= {addr_sh[ADDR_W-5:0], nib_i};
      if (state_q == ST_DATA) begin
        if (cnt == '0) wbyte[3:0] <= nib_i;
        else           wbyte[7:4] <= nib_i;
      end
    end
  end

  // R8: address phase never runs past the length of the decoded cycle kind
  assert_addr_len_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR) |-> (cnt < ((kind_q == K_MEMRD) ? CNT_W'(MEM_NIBS) : CNT_W'(IO_NIBS))));

endmodule

// File: rtl/lpcw_handshake.sv
module lpcw_handshake
  import lpcw_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  lpcw_state_e       state_q,
  input  lpcw_kind_e        kind_q,
  input  logic [ADDR_W-1:0] addr_sh,
  input  logic [7:0]        wbyte,
  input  logic [7:0]        be_rdata,
  input  logic              be_ack,
  output logic              be_valid,
  output logic              be_write,
  output logic [ADDR_W-1:0] be_addr,
  output logic [7:0]        be_wdata,
  output logic [7:0]        rbyte,
  output logic              done_now
);

  logic req_sent;
  logic done_q;
  logic armed;
  logic launch;
  logic accept;
  logic own_accept;

  assign armed      = (state_q == ST_TAR) || (state_q == ST_WAIT);
  assign launch     = armed && !req_sent && !be_valid;
  assign accept     = be_valid && be_ack;
  assign own_accept = accept && req_sent;
  assign done_now   = done_q || own_accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      be_valid <= 1'b0;
      be_write <= 1'b0;
      be_addr  <= '0;
      be_wdata <= '0;
      rbyte    <= '0;
      req_sent <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (launch) begin
        be_valid <= 1'b1;
        be_write <= (kind_q == K_IOWR);
        be_addr  <= addr_sh;
        be_wdata <= wbyte;
      end else if (accept) begin
        be_valid <= 1'b0;
      end
      if (!armed)      req_sent <= 1'b0;
      else if (launch) req_sent <= 1'b1;
      if (!armed)          done_q <= 1'b0;
      else if (own_accept) done_q <= 1'b1;
      if (own_accept) rbyte <= be_rdata;
    end
  end

  // R4, R11: an open request and its payload hold until acknowledged
  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (be_valid && !be_ack) |=> (be_valid && $stable(be_addr) && $stable(be_wdata) && $stable(be_write)));

  // R4: an acknowledged request is withdrawn on the next clock
  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (be_valid && be_ack) |=> !be_valid);

endmodule

// File: rtl/lpcw_drive.sv
module lpcw_drive
  import lpcw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lpcw_state_e state_nx,
  input  logic [7:0]  rbyte,
  output logic [3:0]  nib_o,
  output logic        nib_oe
);

  logic [3:0] nib_d;
  logic       oe_d;

  always_comb begin
    oe_d  = 1'b1;
    nib_d = NIB_TAR;
    case (state_nx)
      ST_WAIT: nib_d = SYNC_LWAIT;
      ST_SYNC: nib_d = SYNC_READY;
      ST_RDLO: nib_d = rbyte[3:0];
      ST_RDHI: nib_d = rbyte[7:4];
      ST_TEND: nib_d = NIB_TAR;
      default: oe_d  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_o  <= NIB_TAR;
      nib_oe <= 1'b0;
    end else begin
      nib_o  <= nib_d;
      nib_oe <= oe_d;
    end
  end

endmodule

// File: rtl/lpcw_target.sv
module lpcw_target
  import lpcw_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int IO_NIBS  = 4,
  parameter int MEM_NIBS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              memrd_en,
  input  logic              bus_frame_n,
  input  logic [3:0]        bus_nib_i,
  output logic [3:0]        bus_nib_o,
  output logic              bus_nib_oe,
  output logic [ADDR_W-1:0] be_addr,
  output logic [7:0]        be_wdata,
  input  logic [7:0]        be_rdata,
  output logic              be_write,
  output logic              be_valid,
  input  logic              be_ack
);

  lpcw_state_e       state_q;
  lpcw_state_e       state_nx;
  lpcw_kind_e        kind_q;
  logic [ADDR_W-1:0] addr_sh;
  logic [7:0]        wbyte;
  logic [7:0]        rbyte;
  logic              done_now;

  lpcw_seq #(.ADDR_W(ADDR_W), .IO_NIBS(IO_NIBS), .MEM_NIBS(MEM_NIBS)) u_seq (
    .clk(clk), .rst(rst), .frame_n(bus_frame_n), .nib_i(bus_nib_i),
    .rd_en(rd_en), .memrd_en(memrd_en), .done_now(done_now),
    .state_q(state_q), .state_nx(state_nx), .kind_q(kind_q),
    .addr_sh(addr_sh), .wbyte(wbyte)
  );

  lpcw_handshake #(.ADDR_W(ADDR_W)) u_hs (
    .clk(clk), .rst(rst), .state_q(state_q), .kind_q(kind_q),
    .addr_sh(addr_sh), .wbyte(wbyte), .be_rdata(be_rdata), .be_ack(be_ack),
    .be_valid(be_valid), .be_write(be_write), .be_addr(be_addr),
    .be_wdata(be_wdata), .rbyte(rbyte), .done_now(done_now)
  );

  lpcw_drive u_drv (
    .clk(clk), .rst(rst), .state_nx(state_nx), .rbyte(rbyte),
    .nib_o(bus_nib_o), .nib_oe(bus_nib_oe)
  );

  // R1: reset leaves the bus released and no request open
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!bus_nib_oe && !be_valid));

  // R6: ready sync of a write is followed by the final turnaround nibble
  assert_sync_then_tar_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_nib_oe && bus_nib_o == SYNC_READY && kind_q == K_IOWR && bus_frame_n)
      |=> (bus_nib_oe && bus_nib_o == NIB_TAR));

  // R6: the final turnaround nibble of a write is followed by release
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_nib_oe && bus_nib_o == NIB_TAR && kind_q == K_IOWR) |=> !bus_nib_oe);

  // R9: an ignored cycle type never drives the bus
  assert_quiet_unsupported_R9: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_NONE) |-> !bus_nib_oe);

  // R10: frame strobe mid-cycle releases the bus on the next clock
  assert_abort_release_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_frame_n && state_q != ST_IDLE && state_q != ST_TYPE) |=> !bus_nib_oe);

endmodule

// File: tb/lpcw_target_test.sv
`timescale 1ns/1ps
module lpcw_target_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b1;
  logic        memrd_en = 1'b1;
  logic        bus_frame_n = 1'b1;
  logic [3:0]  bus_nib_i = 4'hF;
  logic [3:0]  bus_nib_o;
  logic        bus_nib_oe;
  logic [23:0] be_addr;
  logic [7:0]  be_wdata;
  logic [7:0]  be_rdata = 8'h00;
  logic        be_write;
  logic        be_valid;
  logic        be_ack = 1'b0;

  int total = 0;
  int bad = 0;
  int ack_delay = 0;
  bit ack_en = 1'b1;
  bit finished = 1'b0;

  lpcw_target uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .memrd_en(memrd_en),
    .bus_frame_n(bus_frame_n), .bus_nib_i(bus_nib_i),
    .bus_nib_o(bus_nib_o), .bus_nib_oe(bus_nib_oe),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata),
    .be_write(be_write), .be_valid(be_valid), .be_ack(be_ack)
  );

  initial forever #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic f, input logic [3:0] n);
    @(negedge clk);
    bus_frame_n = f;
    bus_nib_i = n;
  endtask

  // back-end responder: acknowledge ack_delay clocks after valid is seen
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (be_ack && !be_valid) be_ack = 1'b0;
      else if (!be_valid) wcnt = 0;
      else if (!be_ack && ack_en) begin
        if (wcnt >= ack_delay) begin be_ack = 1'b1; wcnt = 0; end
        else wcnt++;
      end
    end
  end

  // one full host cycle followed by the target's sync, data and turnaround
  task automatic run_cycle(input logic [3:0] ctype, input logic [31:0] addr, input int nibs,
                           input logic [23:0] exp_addr, input logic [7:0] wdat,
                           input logic [7:0] rdat, input int delay, input bit is_wr, input string tag);
    int waits;
    ack_delay = delay;
    be_rdata = rdat;
    drv(1'b0, 4'h0);
    drv(1'b1, ctype);
    for (int i = 0; i < nibs; i++) drv(1'b1, addr[4*(nibs-1-i) +: 4]);
    if (is_wr) begin
      drv(1'b1, wdat[3:0]);
      drv(1'b1, wdat[7:4]);
    end
    drv(1'b1, 4'hF);
    chk(!bus_nib_oe, {tag, " R5 oe in turnaround 1"}, 32'(bus_nib_oe), 0);
    drv(1'b1, 4'hF);
    chk(!bus_nib_oe, {tag, " R5 oe in turnaround 2"}, 32'(bus_nib_oe), 0);
    chk(be_valid === 1'b1, {tag, " R4 valid raised"}, 32'(be_valid), 1);
    chk(be_addr === exp_addr, {tag, " R2/R8 address"}, 32'(be_addr), 32'(exp_addr));
    chk(be_write === is_wr, {tag, " R3/R7 write flag"}, 32'(be_write), 32'(is_wr));
    if (is_wr) chk(be_wdata === wdat, {tag, " R3 write byte"}, 32'(be_wdata), 32'(wdat));
    waits = 0;
    @(negedge clk);
    while (bus_nib_oe && bus_nib_o == 4'h6 && waits < 100) begin
      waits++;
      @(negedge clk);
    end
    chk(waits == delay, {tag, " R6 long-wait count"}, 32'(waits), 32'(delay));
    chk(bus_nib_oe && bus_nib_o == 4'h0, {tag, " R6 ready sync"}, {27'd0, bus_nib_oe, bus_nib_o}, 32'h10);
    if (!is_wr) begin
      @(negedge clk);
      chk(bus_nib_oe && bus_nib_o == rdat[3:0], {tag, " R7 read low nibble"}, 32'(bus_nib_o), 32'(rdat[3:0]));
      @(negedge clk);
      chk(bus_nib_oe && bus_nib_o == rdat[7:4], {tag, " R7 read high nibble"}, 32'(bus_nib_o), 32'(rdat[7:4]));
    end
    @(negedge clk);
    chk(bus_nib_oe && bus_nib_o == 4'hF, {tag, " R6 final turnaround"}, {27'd0, bus_nib_oe, bus_nib_o}, 32'h1F);
    @(negedge clk);
    chk(!bus_nib_oe, {tag, " R6 release"}, 32'(bus_nib_oe), 0);
    chk(!be_valid, {tag, " R4 valid dropped"}, 32'(be_valid), 0);
  endtask

  task automatic test_reset();
    chk(!bus_nib_oe && !be_valid && !be_write, "R1 reset outputs",
        {29'd0, bus_nib_oe, be_valid, be_write}, 0);
  endtask

  task automatic test_ignored(input logic [3:0] ctype, input string tag);
    bit quiet = 1'b1;
    drv(1'b0, 4'h0);
    drv(1'b1, ctype);
    for (int i = 0; i < 14; i++) begin
      drv(1'b1, 4'(i));
      if (bus_nib_oe || be_valid) quiet = 1'b0;
    end
    chk(quiet, {tag, " R9 ignored cycle stays quiet"}, 32'(quiet), 1);
  endtask

  task automatic test_abort_addr();
    drv(1'b0, 4'h0);
    drv(1'b1, 4'h2);
    drv(1'b1, 4'h1);
    drv(1'b1, 4'h2);
    drv(1'b0, 4'h5);
    drv(1'b1, 4'hF);
    chk(!bus_nib_oe && !be_valid, "R10 abort in address phase", {30'd0, bus_nib_oe, be_valid}, 0);
    drv(1'b1, 4'h2);
    drv(1'b1, 4'h0);
    // restart straight from an aborted address phase
    drv(1'b0, 4'h0);
    drv(1'b1, 4'h2);
    drv(1'b0, 4'h0);
    run_cycle(4'h2, 32'h0000_4321, 4, 24'h004321, 8'h96, 8'h00, 1, 1'b1, "R10 restart");
  endtask

  task automatic test_abort_wait();
    bit held = 1'b1;
    ack_en = 1'b0;
    drv(1'b0, 4'h0);
    drv(1'b1, 4'h2);
    drv(1'b1, 4'hB); drv(1'b1, 4'hE); drv(1'b1, 4'hE); drv(1'b1, 4'hF);
    drv(1'b1, 4'h7); drv(1'b1, 4'h3);
    drv(1'b1, 4'hF);
    drv(1'b1, 4'hF);
    drv(1'b1, 4'hF);
    chk(bus_nib_oe && bus_nib_o == 4'h6, "R6 long-wait while ack held", {27'd0, bus_nib_oe, bus_nib_o}, 32'h16);
    drv(1'b1, 4'hF);
    drv(1'b0, 4'hF);
    drv(1'b1, 4'hF);
    chk(!bus_nib_oe, "R10 abort during long-wait releases bus", 32'(bus_nib_oe), 0);
    for (int i = 0; i < 5; i++) begin
      drv(1'b1, 4'hF);
      if (!be_valid || be_addr != 24'h00BEEF || be_wdata != 8'h37) held = 1'b0;
    end
    chk(held, "R11 request held after abort", {be_valid, 23'd0, be_wdata}, {1'b1, 23'd0, 8'h37});
    ack_en = 1'b1;
    ack_delay = 0;
    repeat (4) drv(1'b1, 4'hF);
    chk(!be_valid, "R11 request closes on ack", 32'(be_valid), 0);
    run_cycle(4'h2, 32'h0000_0101, 4, 24'h000101, 8'hE4, 8'h00, 2, 1'b1, "R10 after wait abort");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    test_reset();
    run_cycle(4'h2, 32'h0000_0080, 4, 24'h000080, 8'h5A, 8'h00, 3, 1'b1, "R2 R3 write A,5");
    run_cycle(4'h2, 32'h0000_FFFF, 4, 24'h00FFFF, 8'hC3, 8'h00, 0, 1'b1, "R6 zero-delay write");
    run_cycle(4'h0, 32'h0000_3F10, 4, 24'h003F10, 8'h00, 8'hA7, 2, 1'b0, "R7 io read");
    run_cycle(4'h4, 32'h12AB_CDEF, 8, 24'hABCDEF, 8'h00, 8'h1E, 1, 1'b0, "R8 mem read");
    test_ignored(4'h3, "type 3");
    rd_en = 1'b0;
    test_ignored(4'h0, "read disabled");
    rd_en = 1'b1;
    memrd_en = 1'b0;
    test_ignored(4'h4, "memory read disabled");
    memrd_en = 1'b1;
    test_abort_addr();
    test_abort_wait();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule